// File: doc/BRIEF.md
# Banked Vectored Interrupt Controller

This block collects up to 96 interrupt requests, organised as three 32-bit banks, and presents them to a processor through one interrupt line and a vector register. Source number n belongs to bank n/32 at bit position n%32. Each source is latched into a pending bit. It reaches the processor only when its enable bit is 1 and its mask bit is 0. The interrupt line is the registered OR of every such active source.

Software reads the vector register to learn which source to service. The vector holds four times the number of the lowest-numbered active source. A vector of zero has two meanings: nothing is active, or source 0 is active. Software tells these apart by reading bit 0 of pending bank 0.

Sources 1 to 95 are level requests and need no acknowledge. Source 0 is an external non-maskable-style request. Its trigger type can be chosen, and it stays pending until software clears it. Access is through a plain 32-bit register bus: an address, read and write strobes, write data, and combinational read data.

Top module: `banked_irq_ctrl`

## Requirements
- R1: Register offsets:
  - vector at 0x00;
  - protection at 0x08;
  - source-0 trigger control at 0x0C;
  - pending bank b at 0x10+4*b;
  - enable bank b at 0x40+4*b;
  - mask bank b at 0x50+4*b.

  Enable and mask banks read back the last value written. A read of any other address returns 0.
- R2: After reset, every enable, mask, pending, protection and trigger-control bit reads 0, and irq_o is 0.
- R3: For each source n from 1 to 95, the pending bit equals src_i[n] as sampled at the previous clock edge. The one exception is the cycle after a write of 1 to that pending bit, in which the bit reads 0.
- R4: A source is active when its pending bit is 1, its enable bit is 1 and its mask bit is 0. irq_o is the OR of all active sources, delayed by one clock.
- R5: The vector register reads 4 times the index of the lowest-numbered active source, with bits 1:0 always 0. It reads 0 when no source is active.
- R6: Once pending bit 0 is set, it stays set until software writes 1 to bit 0 of pending bank 0. Writing 0 to that bit has no effect.
- R7: Trigger control bits 1:0 select how source 0 becomes pending:
  - 0: src_i[0] low (level);
  - 1: src_i[0] high (level);
  - 2: a 1-to-0 transition;
  - 3: a 0-to-1 transition.

  Only bits 1:0 are stored; the upper bits read 0.
- R8: When a source-0 trigger and a software clear of pending bit 0 fall in the same cycle, the trigger wins and the bit stays 1.
- R9: The protection register stores bit 0 only. Its bits 31:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when rd_i is low |
| src_i | input | 96 | Interrupt source inputs |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
Two events can fall in the same cycle: a software write-1-to-clear of a pending bit, and the source that feeds that bit asserting again.

For source 0, the bench holds the source in its level-trigger state while software writes the clear. The bit must still read 1 after that write.

For a level source that stays high, the bench reads the pending bit straight after the clearing edge and again one clock later. It expects 0 and then 1.

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl #(
  parameter int NBANKS = 3,
  parameter int BANK_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] rdata_o,
  input  logic [NBANKS*BANK_W-1:0] src_i,
  output logic              irq_o
);
  localparam int N     = NBANKS * BANK_W;
  localparam int IDX_W = $clog2(N);
  localparam int VEC_A = 'h00, PROT_A = 'h08, TRIG_A = 'h0C;
  localparam int PEND_A = 'h10, EN_A = 'h40, MSK_A = 'h50;

  logic [N-1:0] pend, en, msk, clr, active;
  logic         prot;
  logic [1:0]   trig_mode;
  logic         src0_q, nmi_trig;
  logic [IDX_W-1:0] vec_idx;

  assign active = pend & en & ~msk;

  always_comb begin
    clr = '0;
    for (int b = 0; b < NBANKS; b++)
      if (wr_i && addr_i == ADDR_W'(PEND_A + 4*b)) clr[b*BANK_W +: BANK_W] = wdata_i;
  end

  always_comb begin
    case (trig_mode)
      2'd0: nmi_trig = ~src_i[0];
      2'd1: nmi_trig = src_i[0];
      2'd2: nmi_trig = src0_q & ~src_i[0];
      default: nmi_trig = ~src0_q & src_i[0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0; en <= '0; msk <= '0;
      prot <= 1'b0; trig_mode <= 2'd0;
      src0_q <= 1'b1; irq_o <= 1'b0;
    end else begin
      src0_q     <= src_i[0];
      irq_o      <= |active;
      pend[N-1:1] <= src_i[N-1:1] & ~clr[N-1:1];
      pend[0]    <= nmi_trig | (pend[0] & ~clr[0]);
      if (wr_i && addr_i == ADDR_W'(PROT_A)) prot <= wdata_i[0];
      if (wr_i && addr_i == ADDR_W'(TRIG_A)) trig_mode <= wdata_i[1:0];
      for (int b = 0; b < NBANKS; b++) begin
        if (wr_i && addr_i == ADDR_W'(EN_A + 4*b))  en[b*BANK_W +: BANK_W]  <= wdata_i;
        if (wr_i && addr_i == ADDR_W'(MSK_A + 4*b)) msk[b*BANK_W +: BANK_W] <= wdata_i;
      end
    end
  end

  always_comb begin
    vec_idx = '0;
    for (int i = N-1; i >= 0; i--)
      if (active[i]) vec_idx = IDX_W'(i);
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == ADDR_W'(VEC_A))  rdata_o = BANK_W'(vec_idx) << 2;
      if (addr_i == ADDR_W'(PROT_A)) rdata_o = BANK_W'(prot);
      if (addr_i == ADDR_W'(TRIG_A)) rdata_o = BANK_W'(trig_mode);
      for (int b = 0; b < NBANKS; b++) begin
        if (addr_i == ADDR_W'(PEND_A + 4*b)) rdata_o = pend[b*BANK_W +: BANK_W];
        if (addr_i == ADDR_W'(EN_A + 4*b))   rdata_o = en[b*BANK_W +: BANK_W];
        if (addr_i == ADDR_W'(MSK_A + 4*b))  rdata_o = msk[b*BANK_W +: BANK_W];
      end
    end
  end

  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend[N-1:1] & ~$past(src_i[N-1:1])) == '0));

  // R6
  nmi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && !clr[0]) |=> pend[0]);

  // R4
  vec_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_idx != '0) |=> irq_o);

  // R5
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == ADDR_W'(VEC_A)) |-> (rdata_o[1:0] == 2'b00));

  // R9
  prot_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == ADDR_W'(PROT_A)) |-> (rdata_o[BANK_W-1:1] == '0));
endmodule

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 3;
  localparam int N = NB * 32;

  logic clk = 0, rst_n = 0, wr = 0, rd = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [N-1:0] src;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  banked_irq_ctrl uut (.clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .src_i(src), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(logic [7:0] a, output logic [31:0] d);
    rd = 1; addr = a; #1; d = rdata; rd = 0;
  endtask

  function automatic logic [31:0] exp_vec(logic [N-1:0] act);
    for (int i = 0; i < N; i++) if (act[i]) return 32'(i) << 2;
    return 32'd0;
  endfunction

  task automatic check_pend0(string req, logic e);
    logic [31:0] v;
    rreg(8'h10, v); check(req, {31'd0, v[0]}, {31'd0, e});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [N-1:0] e_en, e_mk, act;
    void'($urandom(32'd2024));
    src = '0; src[0] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset state
    check("R2 irq", {31'd0, irq}, 32'd0);
    foreach (e_en[i]) ;
    for (int b = 0; b < NB; b++) begin
      rreg(8'(8'h10 + 4*b), v); check("R2 pend", v, 0);
      rreg(8'(8'h40 + 4*b), v); check("R2 en", v, 0);
      rreg(8'(8'h50 + 4*b), v); check("R2 mask", v, 0);
    end
    rreg(8'h08, v); check("R2 prot", v, 0);
    rreg(8'h0C, v); check("R2 trig", v, 0);
    rreg(8'h00, v); check("R2 vec", v, 0);

    // R1 unmapped reads and storage
    rreg(8'h04, v); check("R1 unmapped 04", v, 0);
    rreg(8'h30, v); check("R1 unmapped 30", v, 0);
    wreg(8'h60, 32'hFFFFFFFF);
    rreg(8'h60, v); check("R1 unmapped 60", v, 0);
    wreg(8'h44, 32'hA5A55A5A);
    rreg(8'h44, v); check("R1 enable rw", v, 32'hA5A55A5A);
    wreg(8'h58, 32'h0F0F00F0);
    rreg(8'h58, v); check("R1 mask rw", v, 32'h0F0F00F0);

    // R9 protection
    wreg(8'h08, 32'hFFFFFFFF);
    rreg(8'h08, v); check("R9 prot", v, 32'd1);
    wreg(8'h08, 32'h0);
    rreg(8'h08, v); check("R9 prot clr", v, 32'd0);

    // R3 R4 R5 random traffic
    for (int it = 0; it < 40; it++) begin
      @(negedge clk);
      for (int b = 0; b < NB; b++) src[b*32 +: 32] = $urandom;
      if (it % 5 == 0) src[N-1:1] = '0;
      src[0] = 1'b1;
      for (int b = 0; b < NB; b++) begin
        e_en[b*32 +: 32] = $urandom;
        e_mk[b*32 +: 32] = $urandom & $urandom & $urandom;
        wreg(8'(8'h40 + 4*b), e_en[b*32 +: 32]);
        wreg(8'(8'h50 + 4*b), e_mk[b*32 +: 32]);
      end
      @(negedge clk);
      act = {src[N-1:1], 1'b0} & e_en & ~e_mk;
      for (int b = 0; b < NB; b++) begin
        rreg(8'(8'h10 + 4*b), v);
        check("R3 pend random", v, {src[b*32+31 -: 31], b == 0 ? 1'b0 : src[b*32]});
      end
      rreg(8'h00, v); check("R5 vec random", v, exp_vec(act));
      check("R4 irq random", {31'd0, irq}, {31'd0, |act});
    end

    // R4 R5 directed: lowest wins, mask blocks
    src = '0; src[0] = 1'b1; src[70] = 1; src[33] = 1; src[5] = 1;
    for (int b = 0; b < NB; b++) begin wreg(8'(8'h40 + 4*b), 32'hFFFFFFFF); wreg(8'(8'h50 + 4*b), 0); end
    @(negedge clk);
    rreg(8'h00, v); check("R5 lowest", v, 32'd20);
    wreg(8'h50, 32'h20);
    rreg(8'h00, v); check("R5 masked skip", v, 32'd132);
    src[33] = 0; src[70] = 0;
    @(negedge clk);
    rreg(8'h00, v); check("R5 none", v, 0);
    @(negedge clk);
    check("R4 irq none", {31'd0, irq}, 0);
    check_pend0("R5 pend0 clear", 1'b0);

    // R3 clear of a level source still high
    src[40] = 1;
    @(negedge clk); @(negedge clk);
    @(negedge clk); wr = 1; addr = 8'h14; wdata = 32'h100;
    @(negedge clk); wr = 0;
    rreg(8'h14, v); check("R3 cleared cycle", v, 0);
    @(negedge clk);
    rreg(8'h14, v); check("R3 reasserts", v, 32'h100);
    src[40] = 0;
    @(negedge clk);
    rreg(8'h14, v); check("R3 drop", v, 0);

    // R7 rising edge, R6 sticky
    wreg(8'h0C, 32'hFFFFFFFF);
    rreg(8'h0C, v); check("R7 trig width", v, 3);
    wreg(8'h10, 1);
    check_pend0("R7 no edge", 1'b0);
    @(negedge clk); src[0] = 0;
    @(negedge clk); check_pend0("R7 rising ignores low", 1'b0);
    src[0] = 1;
    @(negedge clk); src[0] = 0;
    @(negedge clk);
    check_pend0("R7 rising", 1'b1);
    rreg(8'h00, v); check("R5 vec zero with src0", v, 0);
    check("R4 irq src0", {31'd0, irq}, 1);
    wreg(8'h10, 32'hFFFFFFFE);
    check_pend0("R6 write zero no effect", 1'b1);
    wreg(8'h10, 1);
    check_pend0("R6 cleared", 1'b0);

    // R7 falling edge
    wreg(8'h0C, 2);
    @(negedge clk); src[0] = 1;
    @(negedge clk); check_pend0("R7 falling ignores rise", 1'b0);
    src[0] = 0;
    @(negedge clk); @(negedge clk);
    check_pend0("R7 falling", 1'b1);
    wreg(8'h10, 1);
    check_pend0("R7 falling cleared", 1'b0);

    // R7 active high level and R8 trigger beats clear
    wreg(8'h0C, 1);
    check_pend0("R7 high level idle", 1'b0);
    src[0] = 1;
    @(negedge clk);
    check_pend0("R7 high level", 1'b1);
    wreg(8'h10, 1);
    check_pend0("R8 trigger wins", 1'b1);
    src[0] = 0;
    wreg(8'h10, 1);
    check_pend0("R8 clears once released", 1'b0);

    // R7 active low level
    src[0] = 1;
    wreg(8'h0C, 0);
    wreg(8'h10, 1);
    check_pend0("R7 low level idle", 1'b0);
    src[0] = 0;
    @(negedge clk);
    check_pend0("R7 low level", 1'b1);
    wreg(8'h10, 1);
    check_pend0("R8 low level holds", 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule